// File: doc/BRIEF.md
# I2C Bus Event Interrupt Unit

This unit watches the synchronized clock and data lines of an I2C peripheral and turns bus activity into sticky event flags. It recognises the bus framing conditions (Start, Repeated Start, Stop). It counts clock edges within each byte and decides when an address byte, a data byte, an acknowledge or the end of a counted transfer has happened. Flags for those events are raised at fixed SCL edges.

The protocol engine supplies the mode and match context: whether the device acts as a client or multi-host, whether it is addressed, and whether the current byte matched its address. Software loads a data-byte down-counter, sets a per-flag enable mask, and clears flags by writing ones. A read-only summary output is the OR of all flags. The interrupt output is the OR of the enabled flags only. A separate receive-buffer-full status is raised with every received data byte and is dropped by the receive-buffer read strobe.

Top module: `i2c_evt_irq`

## Requirements
- R1: SDA falling while SCL stays high, with the bus idle, sets flag bit 0 (start) and marks the bus busy.
- R2: The same condition while the bus is busy (no Stop since the last Start) sets flag bit 1 (restart) and leaves bit 0 untouched.
- R3: SDA rising while SCL stays high sets flag bit 2 (stop) and marks the bus idle.
- R4: The falling SCL edge directly after a Start or Restart is not counted. On the 8th counted falling edge, if client_mode_i, addressed_i are high and addr_match_i is low, flag bit 3 (data written) and rxbf_o set. Neither is set at the 7th edge.
- R5: rxbf_o stays set until rxb_rd_i is pulsed. The read does not clear flag bit 3.
- R6: On the 8th counted falling edge, flag bit 4 (address) sets when client_mode_i and addr_match_i are high, and never when client_mode_i is low.
- R7: On the 9th counted falling edge, flag bit 5 (ack time) sets when client_mode_i and addressed_i are high and SDA was low at the 9th rising edge. A high SDA (NACK) leaves it clear.
- R8: On the 9th counted falling edge, flag bit 6 (count) sets when the byte counter holds 1 or 0 at that edge.
- R9: cnt_load_i loads cnt_val_i into the byte counter one cycle later. Each 9th counted falling edge decrements it while it is nonzero, and it holds at zero.
- R10: summary_o is high while any flag bit is set and stays high until every flag is cleared.
- R11: Flags set regardless of the enable mask. irq_o is high only while a flag whose enable bit (loaded by ie_we_i) is set is itself set.
- R12: Writing 1 to a bit of flag_clr_i clears that flag on the next edge. A set in the same cycle wins over the clear.
- R13: A Restart in the middle of a byte restarts the edge count, so the 8th-edge flags appear counted from the Restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL |
| sda_i | input | 1 | Synchronized SDA |
| client_mode_i | input | 1 | Client or multi-host mode active |
| addressed_i | input | 1 | Device currently addressed |
| addr_match_i | input | 1 | Current byte matched own address |
| cnt_load_i | input | 1 | Load byte counter |
| cnt_val_i | input | CNT_W | Byte counter load value |
| rxb_rd_i | input | 1 | Receive buffer read strobe |
| flag_clr_i | input | 7 | Write-1-to-clear flag mask |
| ie_we_i | input | 1 | Enable mask write strobe |
| ie_i | input | 7 | Enable mask value |
| flags_o | output | 7 | Event flags (bit map in R1-R8 numbering above) |
| summary_o | output | 1 | OR of all flags |
| irq_o | output | 1 | OR of enabled flags |
| rxbf_o | output | 1 | Receive buffer full |
| byte_cnt_o | output | CNT_W | Byte counter value |

## Verification
The bench targets the off-by-one edges. It checks that the falling edge right after Start is skipped and that nothing appears on the 7th edge. A miscount would fire data or address flags one bit early or late. It aborts a byte with a Restart, which catches a bit counter that is not reset there. It holds a clear on the same cycle a Start occurs, to catch a clear-wins priority. It drives random mode, match, ACK and counter values, including counter values 0 and 1, to catch a counter that underflows or raises the count flag at the wrong value.

// File: rtl/i2c_evt_pkg.sv
`timescale 1ns/1ps
package i2c_evt_pkg;
  localparam int unsigned NFLAG    = 7;
  localparam int unsigned F_START  = 0;
  localparam int unsigned F_RSTART = 1;
  localparam int unsigned F_STOP   = 2;
  localparam int unsigned F_WR     = 3;
  localparam int unsigned F_ADR    = 4;
  localparam int unsigned F_ACKT   = 5;
  localparam int unsigned F_CNT    = 6;

  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;

  typedef struct packed {
    logic edge8;
    logic edge9;
    logic ack;
    logic cnt_hit;
  } byte_evt_t;
endpackage

// File: rtl/i2c_evt_cond.sv
`timescale 1ns/1ps
module i2c_evt_cond
  import i2c_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);
  logic scl_q, sda_q, busy_q;
  logic hi_both, any_start;

  assign hi_both   = scl_q & scl_i;
  assign any_start = hi_both & sda_q & ~sda_i;

  assign evt_o.start  = any_start & ~busy_q;
  assign evt_o.rstart = any_start & busy_q;
  assign evt_o.stop   = hi_both & ~sda_q & sda_i;
  assign evt_o.rise   = ~scl_q & scl_i;
  assign evt_o.fall   = scl_q & ~scl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (any_start)       busy_q <= 1'b1;
      else if (evt_o.stop) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_evt_bits.sv
`timescale 1ns/1ps
module i2c_evt_bits
  import i2c_evt_pkg::*;
#(
  parameter int unsigned BYTE_CLKS = 9,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bus_evt_t         bus_i,
  input  logic             sda_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  output byte_evt_t        evt_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned BIT_W = $clog2(BYTE_CLKS);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(BYTE_CLKS - 1);
  localparam logic [BIT_W-1:0] DATA = BIT_W'(BYTE_CLKS - 2);

  logic [BIT_W-1:0] bit_q;
  logic [CNT_W-1:0] cnt_q;
  logic             skip_q, ack_q, frame;
  logic             cfall;

  assign frame = bus_i.start | bus_i.rstart;
  assign cfall = bus_i.fall & ~skip_q;

  assign evt_o.edge8   = cfall & (bit_q == DATA);
  assign evt_o.edge9   = cfall & (bit_q == LAST);
  assign evt_o.ack     = ack_q;
  assign evt_o.cnt_hit = evt_o.edge9 & (cnt_q <= CNT_W'(1));
  assign cnt_o         = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      skip_q <= 1'b1;
      ack_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (frame) begin
        bit_q  <= '0;
        skip_q <= 1'b1;
      end else if (bus_i.fall) begin
        if (skip_q)           skip_q <= 1'b0;
        else if (bit_q == LAST) bit_q <= '0;
        else                  bit_q <= bit_q + 1'b1;
      end
      // acknowledge sampled on the 9th rising edge
      if (bus_i.rise && !skip_q && bit_q == LAST) ack_q <= ~sda_i;
      if (cnt_load_i)                             cnt_q <= cnt_val_i;
      else if (evt_o.edge9 && cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/i2c_evt_flags.sv
`timescale 1ns/1ps
module i2c_evt_flags #(
  parameter int unsigned NF = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic          ie_we_i,
  input  logic [NF-1:0] ie_i,
  output logic [NF-1:0] flags_o,
  output logic          summary_o,
  output logic          irq_o
);
  logic [NF-1:0] flg_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '0;
      ie_q  <= '0;
    end else begin
      flg_q <= (flg_q & ~clr_i) | set_i;
      if (ie_we_i) ie_q <= ie_i;
    end
  end

  assign flags_o   = flg_q;
  assign summary_o = |flg_q;
  assign irq_o     = |(flg_q & ie_q);
endmodule

// File: rtl/i2c_evt_irq.sv
`timescale 1ns/1ps
module i2c_evt_irq
  import i2c_evt_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned BYTE_CLKS = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             client_mode_i,
  input  logic             addressed_i,
  input  logic             addr_match_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             rxb_rd_i,
  input  logic [NFLAG-1:0] flag_clr_i,
  input  logic             ie_we_i,
  input  logic [NFLAG-1:0] ie_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             summary_o,
  output logic             irq_o,
  output logic             rxbf_o,
  output logic [CNT_W-1:0] byte_cnt_o
);
  bus_evt_t         bus;
  byte_evt_t        byt;
  logic [NFLAG-1:0] set_v;
  logic             data_rx, rxbf_q;

  i2c_evt_cond u_cond (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (bus)
  );

  i2c_evt_bits #(.BYTE_CLKS(BYTE_CLKS), .CNT_W(CNT_W)) u_bits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_i     (bus),
    .sda_i     (sda_i),
    .cnt_load_i(cnt_load_i),
    .cnt_val_i (cnt_val_i),
    .evt_o     (byt),
    .cnt_o     (byte_cnt_o)
  );

  assign data_rx = byt.edge8 & client_mode_i & addressed_i & ~addr_match_i;

  always_comb begin
    set_v           = '0;
    set_v[F_START]  = bus.start;
    set_v[F_RSTART] = bus.rstart;
    set_v[F_STOP]   = bus.stop;
    set_v[F_WR]     = data_rx;
    set_v[F_ADR]    = byt.edge8 & client_mode_i & addr_match_i;
    set_v[F_ACKT]   = byt.edge9 & client_mode_i & addressed_i & byt.ack;
    set_v[F_CNT]    = byt.cnt_hit;
  end

  i2c_evt_flags #(.NF(NFLAG)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_v),
    .clr_i    (flag_clr_i),
    .ie_we_i  (ie_we_i),
    .ie_i     (ie_i),
    .flags_o  (flags_o),
    .summary_o(summary_o),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rxbf_q <= 1'b0;
    else if (data_rx)  rxbf_q <= 1'b1;
    else if (rxb_rd_i) rxbf_q <= 1'b0;
  end
  assign rxbf_o = rxbf_q;
endmodule

// File: rtl/i2c_evt_irq_chk.sv
`timescale 1ns/1ps
module i2c_evt_irq_chk
  import i2c_evt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             client_mode_i,
  input logic             cnt_load_i,
  input logic             rxb_rd_i,
  input logic [NFLAG-1:0] flag_clr_i,
  input logic [NFLAG-1:0] flags_o,
  input logic             summary_o,
  input logic             irq_o,
  input logic             rxbf_o,
  input logic [CNT_W-1:0] byte_cnt_o
);
  AST_START_XOR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(flags_o[F_START]) && $rose(flags_o[F_RSTART]))); // R2
  AST_ADR_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[F_ADR]) |-> $past(client_mode_i)); // R6
  AST_RXBF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxbf_o && !rxb_rd_i |=> rxbf_o); // R5
  AST_CNT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_cnt_o == '0) && !cnt_load_i |=> byte_cnt_o == '0); // R9
  AST_SUMMARY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(summary_o) |-> $past(flag_clr_i != '0)); // R10
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> summary_o); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_o & $past(flags_o & ~flag_clr_i)) == $past(flags_o & ~flag_clr_i))); // R12
endmodule

bind i2c_evt_irq i2c_evt_irq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/i2c_evt_irq_bench.sv
`timescale 1ns/1ps
module i2c_evt_irq_bench;
  localparam int CW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, cm = 1'b0, ad = 1'b0, am = 1'b0;
  logic ld = 1'b0, rd = 1'b0, iwe = 1'b0;
  logic [CW-1:0] lval = '0;
  logic [6:0] clr = '0, ie = '0, flags;
  logic summ, irq, rxbf;
  logic [CW-1:0] bcnt;
  int errs = 0, checks = 0;
  logic [CW-1:0] exp_cnt = '0;

  always #2.5 clk = ~clk;

  i2c_evt_irq u_i2c_evt_irq (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .client_mode_i(cm), .addressed_i(ad), .addr_match_i(am),
    .cnt_load_i(ld), .cnt_val_i(lval), .rxb_rd_i(rd),
    .flag_clr_i(clr), .ie_we_i(iwe), .ie_i(ie),
    .flags_o(flags), .summary_o(summ), .irq_o(irq), .rxbf_o(rxbf),
    .byte_cnt_o(bcnt));

  function automatic logic e_wr(logic c, logic a, logic m); return c & a & ~m; endfunction
  function automatic logic e_adr(logic c, logic m); return c & m; endfunction
  function automatic logic e_ack(logic c, logic a, logic k); return c & a & k; endfunction
  function automatic logic e_cnt(logic [CW-1:0] c); return c <= 1; endfunction
  function automatic logic [CW-1:0] e_next(logic [CW-1:0] c); return (c == 0) ? c : c - 1; endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic drv(logic c, logic d); scl = c; sda = d; step(); endtask
  task automatic clr_all(); clr = '1; step(); clr = '0; endtask
  task automatic rd_pulse(); rd = 1'b1; step(); rd = 1'b0; endtask
  task automatic do_start(); drv(1, 1); drv(1, 0); drv(0, 0); endtask
  task automatic do_rstart(); drv(0, 1); drv(1, 1); drv(1, 0); drv(0, 0); endtask
  task automatic do_stop(); drv(0, 0); drv(1, 0); drv(1, 1); endtask
  task automatic load(logic [CW-1:0] v);
    lval = v; ld = 1'b1; step(); ld = 1'b0; exp_cnt = v;
    chk("R9", "byte_cnt after load", 32'(bcnt), 32'(v));
  endtask

  task automatic send_byte(logic [7:0] d, logic ackl);
    for (int i = 0; i < 8; i++) begin
      drv(0, d[7-i]); drv(1, d[7-i]); drv(0, d[7-i]);
      if (i == 6) chk("R4", "wr/adr at 7th edge", 32'(flags[4:3]), 32'(0));
    end
    chk("R4", "wr flag 8th edge", 32'(flags[3]), 32'(e_wr(cm, ad, am)));
    chk("R4", "rxbf 8th edge", 32'(rxbf), 32'(e_wr(cm, ad, am)));
    chk("R6", "adr flag 8th edge", 32'(flags[4]), 32'(e_adr(cm, am)));
    drv(0, ~ackl); drv(1, ~ackl); drv(0, ~ackl);
    chk("R7", "ackt flag 9th edge", 32'(flags[5]), 32'(e_ack(cm, ad, ackl)));
    chk("R8", "cnt flag 9th edge", 32'(flags[6]), 32'(e_cnt(exp_cnt)));
    exp_cnt = e_next(exp_cnt);
    chk("R9", "byte_cnt after byte", 32'(bcnt), 32'(exp_cnt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    step(); step();
    chk("R10", "reset flags", 32'(flags), 0);
    chk("R10", "reset summary", 32'(summ), 0);
    chk("R11", "reset irq", 32'(irq), 0);
    chk("R5", "reset rxbf", 32'(rxbf), 0);
    rst_n = 1'b1; step();

    // framing
    do_start();
    chk("R1", "start flags", 32'(flags), 32'h01);
    clr_all();
    do_rstart();
    chk("R2", "restart flags", 32'(flags), 32'h02);
    clr_all();
    do_stop();
    chk("R3", "stop flags", 32'(flags), 32'h04);
    clr_all();

    // random bytes
    do_start();
    for (int n = 0; n < 24; n++) begin
      cm = 1'($urandom); am = 1'($urandom); ad = 1'($urandom) | am;
      if (n % 5 == 0) cm = 1'b0;
      if ($urandom % 3 == 0) load(CW'($urandom % 4));
      clr_all(); rd_pulse();
      send_byte(8'($urandom), 1'($urandom));
      if (n % 7 == 6) do_rstart();
    end
    do_stop();

    // R5: read clears rxbf only
    clr_all(); rd_pulse();
    cm = 1; ad = 1; am = 0; exp_cnt = bcnt;
    do_start(); send_byte(8'hA5, 1'b1);
    rd_pulse();
    chk("R5", "rxbf after read", 32'(rxbf), 0);
    chk("R5", "wr flag kept after read", 32'(flags[3]), 1);

    // R13: restart mid-byte
    drv(0, 1); drv(1, 1); drv(0, 1); drv(0, 0); drv(1, 0); drv(0, 0); drv(0, 1); drv(1, 1); drv(0, 1);
    do_rstart();
    clr_all(); rd_pulse();
    send_byte(8'h3C, 1'b0);
    chk("R13", "wr after restarted byte", 32'(flags[3]), 1);
    do_stop();

    // R10: summary persists
    clr_all();
    do_start(); do_stop();
    chk("R10", "two flags set", 32'(flags & 7'h05), 32'h05);
    clr = 7'h01; step(); clr = '0;
    chk("R10", "summary with one left", 32'(summ), 1);
    clr = 7'h04; step(); clr = '0;
    chk("R10", "summary all clear", 32'(summ), 0);

    // R11: enable gating
    ie = '0; iwe = 1; step(); iwe = 0;
    do_start(); do_stop();
    chk("R11", "stop flag without enable", 32'(flags[2]), 1);
    chk("R11", "irq masked", 32'(irq), 0);
    ie = 7'h04; iwe = 1; step(); iwe = 0;
    chk("R11", "irq enabled", 32'(irq), 1);
    ie = 7'h02; iwe = 1; step(); iwe = 0;
    chk("R11", "irq other enable", 32'(irq), 0);

    // R12: write-1-to-clear, set wins
    clr_all();
    chk("R12", "cleared", 32'(flags), 0);
    drv(1, 1);
    clr = 7'h01; drv(1, 0); clr = '0;
    chk("R12", "set wins over clear", 32'(flags[0]), 1);
    clr = 7'h01; step(); clr = '0;
    chk("R12", "w1c clears", 32'(flags[0]), 0);
    do_stop();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule